// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every incoming Ethernet frame, whether the frame should be kept or dropped, using only its destination address. The first six bytes of the frame arrive as a byte stream (`in_valid`/`in_ready`, with `in_sof` marking the first byte). While they arrive, the block folds each byte into a CRC-32 and assembles the 48-bit address. One clock after the sixth byte is taken it raises `dec_valid` for a single cycle, with the verdict and the address class (unicast, multicast or broadcast).

Unicast frames pass on an exact match with the station address, or when all-physical acceptance is on. Broadcast frames are gated by their own control bit. Other multicast frames are looked up in a bit table indexed by the top bits of the CRC. That table is 16 words of 16 bits. Software loads it one word at a time: it sets a word pointer in the control register, then writes the data register. The `wide_mode` pin selects whether the lookup uses an 8-word (7-bit index) or a 16-word (8-bit index) view of the table. All-multicast and promiscuous settings make every multicast lookup behave as if the table held all ones.

The stream never back-pressures. `in_ready` is low only during reset. A byte is consumed in every cycle where `in_valid` and `in_ready` are both high, so a source may insert idle cycles freely. Bytes after the sixth, up to the next start of frame, are dropped.

Top module: `rx_addr_filter`

## Requirements
- R1: `in_ready` is low while `rst_n` is low and high in every cycle after reset. After reset `dec_valid` is low, the control bits are clear and all table words are zero.
- R2: `dec_valid` is a one-cycle pulse. It appears in the cycle after the sixth address byte is taken. Bytes taken after the sixth and before the next `in_sof` produce no pulse. Bytes taken without a preceding `in_sof` byte produce no pulse.
- R3: A byte taken with `in_sof` high always becomes byte 0 of a new address. Any partly collected address is discarded, and the CRC restarts from all ones.
- R4: With the enable bit (control bit 31) clear, every decision has `dec_accept` low.
- R5: A destination whose byte 0 has bit 0 clear is unicast. Byte k of the address is compared with `sta_addr[8k+7:8k]`. It is accepted on an exact match, or on any address when all-physical (control bit 28) is set.
- R6: An all-ones destination is broadcast. It is accepted only when the broadcast bit (control bit 30) or the promiscuous bit is set.
- R7: Any other destination with byte 0 bit 0 set is multicast. A CRC-32 runs over the six bytes, each byte taken LSB first. It uses the reflected polynomial 0xEDB88320, starts from all ones and applies no final inversion. The index is CRC bits [31:25] when `wide_mode` is 0 and bits [31:24] when it is 1. Index bits above the low four pick the table word, and the low four pick the bit. The frame is accepted when that bit is 1.
- R8: A control write (`cfg_sel`=0) loads the word pointer from `cfg_wdata[20:16]`. A following data write (`cfg_sel`=1) stores `cfg_wdata[15:0]` into table word (pointer − 4). Data writes while the pointer is below 4 or above 19 change no table word.
- R9: With the all-multicast bit (control bit 29) set, every multicast destination is accepted whatever the table holds.
- R10: The promiscuous bit (control bit 27) has the same effect as setting the broadcast, all-multicast and all-physical bits together.
- R11: `dec_class` reports 2'b00 for unicast, 2'b01 for multicast and 2'b11 for broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream ready, high whenever out of reset |
| in_sof | input | 1 | Marks the byte as the first of a frame |
| in_data | input | 8 | Stream byte |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the control register, 1 the table data register |
| cfg_wdata | input | 32 | Register write data |
| wide_mode | input | 1 | 1 selects the 16-word table view, 0 the 8-word view |
| sta_addr | input | 48 | Station address, byte 0 in bits [7:0] |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted, valid with dec_valid |
| dec_class | output | 2 | Destination class, valid with dec_valid |

## Verification
Unicast frames are tried both matching and not matching the station address. This separates the exact compare from the all-physical override. Broadcast frames are sent with the broadcast bit on and off. Multicast frames are checked against a table that holds one set bit, in each of the two table views. This shows that the CRC bits and the word/bit split are chosen correctly: a neighbouring address must fall through. Further cases cover out-of-range pointer writes, a restart in the middle of an address, idle cycles inside the address, trailing bytes, and bytes sent without a start marker. These show that strobes come only from complete, properly started addresses.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'b00,
    CLS_MULTI = 2'b01,
    CLS_BCAST = 2'b11
  } dst_class_e;

  typedef struct packed {
    logic en;
    logic bcast;
    logic allmulti;
    logic allphys;
    logic promisc;
  } filt_ctl_t;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // one byte through the reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY_REFL : 32'h0);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int WORD_W = 16,
  parameter int BASE   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic                         cfg_sel,
  input  logic [31:0]                  cfg_wdata,
  output filt_ctl_t                    ctl_o,
  output logic [WORDS-1:0][WORD_W-1:0] tbl_o
);

  localparam int PTR_LSB = 16;
  localparam int PTR_W   = $clog2(BASE + WORDS + 1);
  localparam logic [PTR_W-1:0] BASE_P = PTR_W'(BASE);
  localparam logic [PTR_W-1:0] LIM_P  = PTR_W'(BASE + WORDS);
  localparam int BIT_EN = 31;
  localparam int BIT_BC = 30;
  localparam int BIT_AM = 29;
  localparam int BIT_AP = 28;
  localparam int BIT_PR = 27;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] word_sel;
  logic             ptr_hit;
  logic             wr_ctl;
  logic             wr_data;

  assign wr_ctl   = cfg_wr && !cfg_sel;
  assign wr_data  = cfg_wr && cfg_sel;
  assign ptr_hit  = (ptr_q >= BASE_P) && (ptr_q < LIM_P);
  assign word_sel = ptr_q - BASE_P;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ctl_o <= '0;
    end else if (wr_ctl) begin
      ptr_q          <= cfg_wdata[PTR_LSB +: PTR_W];
      ctl_o.en       <= cfg_wdata[BIT_EN];
      ctl_o.bcast    <= cfg_wdata[BIT_BC];
      ctl_o.allmulti <= cfg_wdata[BIT_AM];
      ctl_o.allphys  <= cfg_wdata[BIT_AP];
      ctl_o.promisc  <= cfg_wdata[BIT_PR];
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_data && ptr_hit && (word_sel == PTR_W'(w)))
        word_q <= cfg_wdata[WORD_W-1:0];
    end
    assign tbl_o[w] = word_q;
  end

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[BIT_PR-1:PTR_LSB+PTR_W],
                             cfg_wdata[PTR_LSB-1:WORD_W]};

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !ptr_hit) |=> $stable(tbl_o)); // R8

endmodule

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
  import rxf_pkg::*;
#(
  parameter int BYTES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_i,
  input  logic               sof_i,
  input  logic [7:0]         data_i,
  output logic               last_o,
  output logic [31:0]        crc_next_o,
  output logic [BYTES*8-1:0] addr_next_o
);

  localparam int CNT_W = $clog2(BYTES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTES);

  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   pos;
  logic [31:0]        crc_q;
  logic [31:0]        crc_base;
  logic [BYTES*8-1:0] addr_q;
  logic               take;

  // bytes count only inside a started, unfinished address
  assign take     = beat_i && (sof_i || (cnt_q != '0 && cnt_q != FULL));
  assign pos      = sof_i ? '0 : cnt_q;
  assign crc_base = sof_i ? 32'hFFFF_FFFF : crc_q;
  assign crc_next_o = crc_step_byte(crc_base, data_i);
  assign last_o   = take && (pos == FULL - CNT_W'(1));

  always_comb begin
    addr_next_o = sof_i ? '0 : addr_q;
    for (int b = 0; b < BYTES; b++) begin
      if (pos == CNT_W'(b))
        addr_next_o[b*8 +: 8] = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      crc_q  <= 32'hFFFF_FFFF;
      addr_q <= '0;
    end else if (take) begin
      cnt_q  <= pos + CNT_W'(1);
      crc_q  <= crc_next_o;
      addr_q <= addr_next_o;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL); // R2

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int BYTES  = 6,
  parameter int WORDS  = 16,
  parameter int WORD_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         last_i,
  input  logic [31:0]                  crc_i,
  input  logic [BYTES*8-1:0]           addr_i,
  input  logic [BYTES*8-1:0]           sta_addr_i,
  input  logic                         wide_i,
  input  filt_ctl_t                    ctl_i,
  input  logic [WORDS-1:0][WORD_W-1:0] tbl_i,
  output logic                         dec_valid_o,
  output logic                         dec_accept_o,
  output dst_class_e                   dec_class_o
);

  localparam int IDX_W = $clog2(WORDS * WORD_W);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int SEL_W = IDX_W - BIT_W;

  logic             is_bc;
  logic             is_mc;
  logic [IDX_W-1:0] idx;
  logic [SEL_W-1:0] wsel;
  logic [BIT_W-1:0] bsel;
  logic             hash_hit;
  logic             acc_bc;
  logic             acc_mc;
  logic             acc_ap;
  logic             verdict;
  dst_class_e       cls;

  assign is_bc = &addr_i;
  assign is_mc = addr_i[0];

  assign idx  = wide_i ? crc_i[31 -: IDX_W] : {1'b0, crc_i[31 -: IDX_W-1]};
  assign wsel = idx[IDX_W-1:BIT_W];
  assign bsel = idx[BIT_W-1:0];
  assign hash_hit = tbl_i[wsel][bsel];

  assign acc_bc = ctl_i.bcast    || ctl_i.promisc;
  assign acc_mc = ctl_i.allmulti || ctl_i.promisc;
  assign acc_ap = ctl_i.allphys  || ctl_i.promisc;

  always_comb begin
    if (is_bc) begin
      cls     = CLS_BCAST;
      verdict = acc_bc;
    end else if (is_mc) begin
      cls     = CLS_MULTI;
      verdict = acc_mc || hash_hit;
    end else begin
      cls     = CLS_UNI;
      verdict = acc_ap || (addr_i == sta_addr_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid_o  <= 1'b0;
      dec_accept_o <= 1'b0;
      dec_class_o  <= CLS_UNI;
    end else begin
      dec_valid_o <= last_i;
      if (last_i) begin
        dec_accept_o <= ctl_i.en && verdict;
        dec_class_o  <= cls;
      end
    end
  end

  logic unused_crc_bits;
  assign unused_crc_bits = ^crc_i[31-IDX_W:0];

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int BYTES  = 6,
  parameter int WORDS  = 16,
  parameter int WORD_W = 16,
  parameter int BASE   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sof,
  input  logic [7:0]           in_data,
  input  logic                 cfg_wr,
  input  logic                 cfg_sel,
  input  logic [31:0]          cfg_wdata,
  input  logic                 wide_mode,
  input  logic [BYTES*8-1:0]   sta_addr,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic [1:0]           dec_class
);

  filt_ctl_t                    ctl;
  logic [WORDS-1:0][WORD_W-1:0] tbl;
  logic                         beat;
  logic                         last;
  logic [31:0]                  crc_next;
  logic [BYTES*8-1:0]           addr_next;
  dst_class_e                   cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign beat = in_valid && in_ready;

  rxf_cfg_regs #(.WORDS(WORDS), .WORD_W(WORD_W), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctl_o(ctl), .tbl_o(tbl)
  );

  rxf_addr_capture #(.BYTES(BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .beat_i(beat), .sof_i(in_sof),
    .data_i(in_data), .last_o(last), .crc_next_o(crc_next),
    .addr_next_o(addr_next)
  );

  rxf_decide #(.BYTES(BYTES), .WORDS(WORDS), .WORD_W(WORD_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .last_i(last), .crc_i(crc_next),
    .addr_i(addr_next), .sta_addr_i(sta_addr), .wide_i(wide_mode),
    .ctl_i(ctl), .tbl_i(tbl), .dec_valid_o(dec_valid),
    .dec_accept_o(dec_accept), .dec_class_o(cls)
  );

  assign dec_class = cls;

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready); // R1

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R2

  AST_STROBE_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_ready)); // R2

  AST_DISABLED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !$past(ctl.en)) |-> !dec_accept); // R4

  AST_BCAST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 2'b11 && !$past(ctl.bcast || ctl.promisc))
      |-> !dec_accept); // R6

endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        wide_mode = 1'b1;
  logic [47:0] sta_addr = 48'h6655_4433_2200;
  logic        dec_valid;
  logic        dec_accept;
  logic [1:0]  dec_class;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // shadow of the programmed state
  logic        s_en, s_bc, s_am, s_ap, s_pr;
  logic [15:0] s_tbl [16];

  always #5 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_data(in_data), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .wide_mode(wide_mode), .sta_addr(sta_addr),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_class(dec_class)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] hash_index(input logic [47:0] a, input logic wide);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      if (c[0] ^ a[k]) c = (c >> 1) ^ 32'hEDB88320;
      else             c = c >> 1;
    end
    return wide ? c[31:24] : {1'b0, c[31:25]};
  endfunction

  function automatic logic exp_accept(input logic [47:0] a);
    logic [7:0] ix;
    if (!s_en) return 1'b0;
    if (a == '1) return s_bc | s_pr;
    if (a[0]) begin
      if (s_am | s_pr) return 1'b1;
      ix = hash_index(a, wide_mode);
      return s_tbl[ix[7:4]][ix[3:0]];
    end
    return (a == sta_addr) | s_ap | s_pr;
  endfunction

  function automatic logic [1:0] exp_class(input logic [47:0] a);
    if (a == '1) return 2'b11;
    return a[0] ? 2'b01 : 2'b00;
  endfunction

  task automatic reg_write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_ctl(input logic en, bc, am, ap, pr, input logic [4:0] ptr);
    s_en = en; s_bc = bc; s_am = am; s_ap = ap; s_pr = pr;
    reg_write(1'b0, {en, bc, am, ap, pr, 6'b0, ptr, 16'h0});
  endtask

  task automatic tbl_write(input logic [4:0] ptr, input logic [15:0] v);
    set_ctl(s_en, s_bc, s_am, s_ap, s_pr, ptr);
    reg_write(1'b1, {16'h0, v});
    if (ptr >= 5'd4 && ptr <= 5'd19) s_tbl[ptr - 5'd4] = v;
  endtask

  task automatic drive_byte(input logic sof, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_data = d;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic send_addr(input logic [47:0] a, input string req);
    for (int i = 0; i < 6; i++) drive_byte(i == 0, a[8*i +: 8]);
    idle_cycle();
    chk(dec_valid == 1'b1, req, "strobe after sixth byte", dec_valid, 1);
    chk(dec_accept == exp_accept(a), req, "accept", dec_accept, exp_accept(a));
    chk(dec_class == exp_class(a), req, "class", dec_class, exp_class(a));
    idle_cycle();
    chk(dec_valid == 1'b0, req, "strobe one cycle", dec_valid, 0);
  endtask

  task automatic clear_table();
    for (int w = 0; w < 16; w++) tbl_write(5'(w + 4), 16'h0);
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(dec_valid == 1'b0, "R1", "no strobe after reset", dec_valid, 0);
  endtask

  task automatic t_disabled();
    set_ctl(0, 1, 1, 1, 1, 5'd0);
    send_addr(sta_addr, "R4");
    send_addr(48'hFFFF_FFFF_FFFF, "R4");
  endtask

  task automatic t_unicast();
    set_ctl(1, 0, 0, 0, 0, 5'd0);
    send_addr(sta_addr, "R5");
    send_addr(48'h6655_4433_2300, "R5");
    set_ctl(1, 0, 0, 1, 0, 5'd0);
    send_addr(48'h0102_0304_0506, "R5");
  endtask

  task automatic t_broadcast();
    set_ctl(1, 1, 0, 0, 0, 5'd0);
    send_addr(48'hFFFF_FFFF_FFFF, "R6");
    set_ctl(1, 0, 1, 0, 0, 5'd0);
    send_addr(48'hFFFF_FFFF_FFFF, "R6");
  endtask

  task automatic t_hash();
    logic [47:0] m1 = 48'h4433_2211_0001;
    logic [47:0] m2 = 48'h6655_4433_2203;
    logic [7:0]  ix;
    set_ctl(1, 0, 0, 0, 0, 5'd0);
    clear_table();
    wide_mode = 1'b1;
    send_addr(m1, "R7");
    ix = hash_index(m1, 1'b1);
    tbl_write(5'(ix[7:4]) + 5'd4, 16'(1) << ix[3:0]);
    send_addr(m1, "R7");
    send_addr(m2, "R7");
    // 8-word view uses one fewer CRC bit
    clear_table();
    wide_mode = 1'b0;
    ix = hash_index(m1, 1'b0);
    tbl_write(5'(ix[7:4]) + 5'd4, 16'(1) << ix[3:0]);
    send_addr(m1, "R7");
    send_addr(m2, "R7");
    chk(exp_accept(m1) == 1'b1, "R8", "model sanity", exp_accept(m1), 1);
    // data writes with the pointer outside the window are dropped
    tbl_write(5'd3, 16'hFFFF);
    tbl_write(5'd20, 16'hFFFF);
    send_addr(m2, "R8");
    send_addr(48'h1234_5678_9A01, "R8");
  endtask

  task automatic t_allmulti();
    clear_table();
    set_ctl(1, 0, 1, 0, 0, 5'd0);
    send_addr(48'h4433_2211_0001, "R9");
    send_addr(48'h6655_4433_2203, "R9");
    send_addr(48'h6655_4433_2301, "R9");
  endtask

  task automatic t_promisc();
    set_ctl(1, 0, 0, 0, 1, 5'd0);
    send_addr(48'h0102_0304_0500, "R10");
    send_addr(48'hFFFF_FFFF_FFFF, "R10");
    send_addr(48'h0102_0304_0507, "R10");
    set_ctl(1, 0, 0, 0, 0, 5'd0);
    send_addr(48'h0102_0304_0500, "R11");
  endtask

  task automatic t_framing();
    set_ctl(1, 0, 0, 0, 0, 5'd0);
    // restart in the middle of an address
    drive_byte(1, 8'h00); drive_byte(0, 8'h99); drive_byte(0, 8'h88);
    for (int i = 0; i < 6; i++) drive_byte(i == 0, sta_addr[8*i +: 8]);
    idle_cycle();
    chk(dec_valid && dec_accept, "R3", "restart takes new address",
        {dec_valid, dec_accept}, 2'b11);
    idle_cycle();
    // idle cycles inside the address and trailing bytes
    drive_byte(1, sta_addr[7:0]); drive_byte(0, sta_addr[15:8]);
    idle_cycle(); idle_cycle();
    for (int i = 2; i < 6; i++) drive_byte(0, sta_addr[8*i +: 8]);
    drive_byte(0, 8'h77);
    chk(dec_valid && dec_accept, "R2", "strobe with gaps", {dec_valid, dec_accept}, 2'b11);
    drive_byte(0, 8'h66);
    chk(dec_valid == 1'b0, "R2", "no strobe on trailing bytes", dec_valid, 0);
    for (int i = 0; i < 8; i++) drive_byte(0, 8'h55);
    idle_cycle();
    chk(dec_valid == 1'b0, "R2", "no strobe after trailing run", dec_valid, 0);
    // bytes without a start marker
    for (int i = 0; i < 6; i++) begin
      drive_byte(0, sta_addr[8*i +: 8]);
      chk(dec_valid == 1'b0, "R2", "no strobe without sof", dec_valid, 0);
    end
    idle_cycle();
    chk(dec_valid == 1'b0, "R2", "no strobe without sof", dec_valid, 0);
  endtask

  initial begin
    s_en = 0; s_bc = 0; s_am = 0; s_ap = 0; s_pr = 0;
    for (int w = 0; w < 16; w++) s_tbl[w] = '0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R1", "ready low in reset", in_ready, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    set_ctl(1, 0, 0, 0, 0, 5'd0);
    send_addr(48'h4433_2211_0001, "R1");
    t_disabled();
    t_unicast();
    t_broadcast();
    t_hash();
    t_allmulti();
    t_promisc();
    t_framing();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule